// File: doc/BRIEF.md
# Sixteen-Bit Accumulator ALU

This block is the arithmetic and logic stage of a small 16-bit accumulator machine. The accumulator A is always the left operand. The right operand arrives on a second 16-bit input, and the surrounding datapath chooses whether it comes from a register, an immediate or memory. A 4-bit function code selects one of nine operations. The block returns the result combinationally, together with a write-enable for A. It also keeps a registered set of zero, negative and carry flags, which take their new values on the clock edge that ends a valid operation.

Compare runs the subtraction and updates only the flags, so A keeps its value. When the operand is an immediate, only the six two-operand codes (add through XOR) are legal. Shift and swap act on A alone. Codes outside the table, and cycles with no valid operation, leave both A and the flags untouched. There is no overflow flag in this stage, so the machine's overflow bit is never affected here.

Top module: `acc_alu_core`

## Requirements
- R1: Code 1 (add) gives result = A + B modulo 2^16 and a_we = 1, and the carry flag takes the carry out of bit 15.
- R2: Code 2 (subtract) gives result = A - B modulo 2^16 and a_we = 1, and the carry flag is set exactly when A < B as unsigned numbers (borrow).
- R3: Code 3 (compare) sets the flags exactly as subtract would. Its result output shows A - B, but a_we stays 0.
- R4: Codes 4, 5 and 6 give the bitwise AND, OR and XOR of A and B with a_we = 1, and they clear the carry flag.
- R5: Code 7 (shift left) gives {A[14:0], 0} with a_we = 1, and the carry flag takes A[15]. B is ignored.
- R6: Code 8 (shift right) gives {0, A[15:1]} with a_we = 1, and the carry flag takes A[0]. B is ignored.
- R7: Code 9 (swap) gives {A[7:0], A[15:8]} with a_we = 1 and clears the carry flag.
- R8: After any legal operation, the zero flag is 1 exactly when the result was 0000h, and the negative flag equals result bit 15. Both are seen one clock after the operation.
- R9: Codes 0 and 10 to 15 give a_we = 0 and leave all three flags unchanged.
- R10: With imm_form = 1, codes 7, 8 and 9 are illegal: a_we = 0 and the flags are unchanged.
- R11: With op_valid = 0, a_we is 0 and the flags are unchanged, whatever the code.
- R12: While rst_n is low, all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flags update on its rising edge |
| rst_n | input | 1 | Active-low reset for the flags |
| op_valid | input | 1 | An ALU operation is issued in this cycle |
| func | input | 4 | Function code (1 to 9 legal) |
| imm_form | input | 1 | The right operand is an immediate |
| a_in | input | 16 | Accumulator value (left operand) |
| b_in | input | 16 | Right operand |
| result | output | 16 | Operation result (0 for an illegal code) |
| a_we | output | 1 | Write the result back into A |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / borrow flag |

## Verification
The bench aims at the edges of the carry chain:
- FFFFh + 1 has to give zero with a carry. A design that drops bit 16 shows carry 0.
- 0 - 1 has to give a borrow and a negative result. A design with carry and borrow reversed reports carry 1 for A >= B instead.

Shifting 8000h left or 0001h right must move the departing bit into carry and leave a zero result; a design with the fill or the direction wrong gives a nonzero result or the wrong carry. Compare with equal operands must set zero and never assert the write. A design that treats compare as subtract corrupts A. Unused codes, shift or swap with an immediate operand, and idle cycles all come right after flag-setting operations. A design that decodes too loosely would therefore change flags that must hold.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
    localparam int FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_NONE = 4'd0,
        FN_ADD  = 4'd1,
        FN_SUB  = 4'd2,
        FN_CMP  = 4'd3,
        FN_AND  = 4'd4,
        FN_OR   = 4'd5,
        FN_XOR  = 4'd6,
        FN_SHL  = 4'd7,
        FN_SHR  = 4'd8,
        FN_SWAP = 4'd9
    } alu_fn_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
    } alu_flags_t;
endpackage

// File: rtl/acc_alu_addsub.sv
`timescale 1ns/1ps
// Add or subtract with a W+1 bit sum; the top bit is the carry on add
// and the borrow on subtract.
module acc_alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         carry
);
    logic [W:0] ext;

    always_comb begin
        if (do_sub) ext = {1'b0, a} - {1'b0, b};
        else        ext = {1'b0, a} + {1'b0, b};
        sum   = ext[W-1:0];
        carry = ext[W];
    end
endmodule

// File: rtl/acc_alu_bitwise.sv
`timescale 1ns/1ps
// Logic, single-bit shifts and half swap.
module acc_alu_bitwise
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         carry
);
    localparam int HALF = W / 2;

    always_comb begin
        res   = '0;
        carry = 1'b0;
        unique case (fn)
            FN_AND:  res = a & b;
            FN_OR:   res = a | b;
            FN_XOR:  res = a ^ b;
            FN_SHL: begin
                res   = {a[W-2:0], 1'b0};
                carry = a[W-1];
            end
            FN_SHR: begin
                res   = {1'b0, a[W-1:1]};
                carry = a[0];
            end
            FN_SWAP: res = {a[HALF-1:0], a[W-1:HALF]};
            default: begin
                res   = '0;
                carry = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/acc_alu_flagreg.sv
`timescale 1ns/1ps
module acc_alu_flagreg
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] res,
    input  logic         carry,
    output alu_flags_t   flags_q
);
    alu_flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (upd) begin
            flags_d.z = (res == '0);
            flags_d.n = res[W-1];
            flags_d.c = carry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/acc_alu_core.sv
`timescale 1ns/1ps
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [FN_W-1:0] func,
    input  logic            imm_form,
    input  logic [W-1:0]    a_in,
    input  logic [W-1:0]    b_in,
    output logic [W-1:0]    result,
    output logic            a_we,
    output logic            flag_z,
    output logic            flag_n,
    output logic            flag_c
);
    alu_fn_e    fn;
    logic       legal;
    logic       is_arith;
    logic [W-1:0] as_sum, bw_res;
    logic       as_c, bw_c, sel_c;
    alu_flags_t flags_q;

    assign fn = alu_fn_e'(func);

    always_comb begin
        legal    = 1'b0;
        is_arith = 1'b0;
        unique case (fn)
            FN_ADD, FN_SUB, FN_CMP: begin
                legal    = op_valid;
                is_arith = 1'b1;
            end
            FN_AND, FN_OR, FN_XOR: legal = op_valid;
            FN_SHL, FN_SHR, FN_SWAP: legal = op_valid && !imm_form;
            default: legal = 1'b0;
        endcase
    end

    acc_alu_addsub #(.W(W)) i_addsub (
        .a      (a_in),
        .b      (b_in),
        .do_sub (fn != FN_ADD),
        .sum    (as_sum),
        .carry  (as_c)
    );

    acc_alu_bitwise #(.W(W)) i_bitwise (
        .fn    (fn),
        .a     (a_in),
        .b     (b_in),
        .res   (bw_res),
        .carry (bw_c)
    );

    always_comb begin
        result = '0;
        sel_c  = 1'b0;
        if (legal) begin
            result = is_arith ? as_sum : bw_res;
            sel_c  = is_arith ? as_c   : bw_c;
        end
        a_we = legal && (fn != FN_CMP);
    end

    acc_alu_flagreg #(.W(W)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (legal),
        .res     (result),
        .carry   (sel_c),
        .flags_q (flags_q)
    );

    assign flag_z = flags_q.z;
    assign flag_n = flags_q.n;
    assign flag_c = flags_q.c;
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [3:0]   func,
    input logic         imm_form,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] result,
    input logic         a_we,
    input logic         flag_z,
    input logic         flag_n,
    input logic         flag_c
);
    logic ok_op;
    assign ok_op = op_valid && func >= 4'd1 && func <= 4'd9 &&
                   !(imm_form && func >= 4'd7);

    assert_add_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && func == 4'd1) |-> (result == W'(a_in + b_in)));

    assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && func == 4'd3) |-> !a_we);

    assert_shl_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !imm_form && func == 4'd7) |=> (flag_c == $past(a_in[W-1])));

    assert_shr_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !imm_form && func == 4'd8) |=> (flag_c == $past(a_in[0])));

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ok_op |=> (flag_z == ($past(result) == '0)));

    assert_neg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ok_op |=> (flag_n == $past(result[W-1])));

    assert_bad_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'd0 || func > 4'd9) |-> !a_we);

    assert_imm_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_form && func >= 4'd7) |-> !a_we);

    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_op |=> $stable({flag_z, flag_n, flag_c}));
endmodule

bind acc_alu_core acc_alu_chk #(.W(W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .func     (func),
    .imm_form (imm_form),
    .a_in     (a_in),
    .b_in     (b_in),
    .result   (result),
    .a_we     (a_we),
    .flag_z   (flag_z),
    .flag_n   (flag_n),
    .flag_c   (flag_c)
);

// File: tb/test_acc_alu_core.sv
`timescale 1ns/1ps
module test_acc_alu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  func = '0;
    logic        imm_form = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic [15:0] result;
    logic        a_we;
    logic        flag_z, flag_n, flag_c;

    int n_chk = 0;
    int n_fail = 0;
    int mz = 0, mn = 0, mc = 0;

    always #4 clk = ~clk;

    acc_alu_core i_acc_alu_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .func(func),
        .imm_form(imm_form), .a_in(a_in), .b_in(b_in), .result(result),
        .a_we(a_we), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(int f);
        case (f)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4, 5, 6: return "R4";
            7: return "R5";
            8: return "R6";
            9: return "R7";
            default: return "R9";
        endcase
    endfunction

    // One operation per clock; the model runs alongside.
    task automatic step(bit v, int f, int a, int b, bit imm);
        int res, cy;
        bit ok, we;
        string tg;
        @(negedge clk);
        op_valid = v; func = 4'(f); a_in = 16'(a); b_in = 16'(b); imm_form = imm;
        ok = v && f >= 1 && f <= 9 && !(imm && f >= 7);
        we = ok && f != 3;
        tg = !v ? "R11" : (imm && f >= 7 && f <= 9) ? "R10" : tag_of(f);
        res = 0; cy = 0;
        case (f)
            1: begin res = (a + b) & 16'hFFFF; cy = ((a + b) > 16'hFFFF) ? 1 : 0; end
            2, 3: begin res = (a - b) & 16'hFFFF; cy = (a < b) ? 1 : 0; end
            4: res = a & b;
            5: res = a | b;
            6: res = a ^ b;
            7: begin res = (a * 2) & 16'hFFFF; cy = (a / 32768) % 2; end
            8: begin res = a / 2; cy = a % 2; end
            9: res = ((a % 256) * 256) + (a / 256);
            default: ;
        endcase
        #1;
        chk(tg, 32'(a_we), 32'(we));
        if (ok) chk(tg, 32'(result), 32'(res));
        @(posedge clk);
        #1;
        if (ok) begin
            mz = (res == 0) ? 1 : 0;
            mn = res / 32768;
            mc = cy;
        end
        chk("R8", 32'(flag_z), 32'(mz));
        chk("R8", 32'(flag_n), 32'(mn));
        chk(tg, 32'(flag_c), 32'(mc));
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R12", 32'({flag_z, flag_n, flag_c}), 32'(0));
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 1, 16'hFFFF, 16'h0001, 0);   // R1 wrap to zero, carry out
        step(1, 1, 16'h1234, 16'h1111, 1);   // R1 immediate form
        step(1, 2, 16'h0000, 16'h0001, 0);   // R2 borrow, negative
        step(1, 2, 16'h5000, 16'h1000, 0);   // R2 no borrow
        step(1, 3, 16'h4242, 16'h4242, 0);   // R3 equal -> zero, no write
        step(1, 3, 16'h0001, 16'h8000, 1);   // R3 borrow
        step(1, 4, 16'hF0F0, 16'h0FF0, 0);   // R4 AND clears carry
        step(1, 5, 16'h8000, 16'h0001, 1);   // R4 OR
        step(1, 6, 16'hAAAA, 16'hAAAA, 0);   // R4 XOR to zero
        step(1, 7, 16'h8000, 16'h1234, 0);   // R5 bit 15 to carry, zero
        step(1, 7, 16'h4001, 16'hFFFF, 0);   // R5 negative
        step(1, 8, 16'h0001, 16'hFFFF, 0);   // R6 bit 0 to carry, zero
        step(1, 8, 16'h8000, 16'h0000, 0);   // R6 zero fill
        step(1, 9, 16'h1234, 16'h0000, 0);   // R7 swap
        step(1, 2, 16'h0000, 16'h0001, 0);   // set z=0 n=1 c=1
        step(1, 0, 16'h0000, 16'h0000, 0);   // R9 code 0
        step(1, 10, 16'h0000, 16'h0000, 0);  // R9
        step(1, 15, 16'h0000, 16'h0000, 0);  // R9
        step(1, 7, 16'h0000, 16'h0000, 1);   // R10 shift with immediate
        step(1, 9, 16'h0000, 16'h0000, 1);   // R10 swap with immediate
        step(0, 1, 16'h0000, 16'h0000, 0);   // R11 idle add
        step(0, 3, 16'h0000, 16'h0000, 0);   // R11 idle compare

        for (int i = 0; i < 400; i++) begin
            int f = $urandom_range(0, 15);
            int a = $urandom_range(0, 65535);
            int b = $urandom_range(0, 65535);
            bit v = ($urandom_range(0, 7) != 0);
            bit im = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) == 0) a = 0;
            step(v, f, a, b, im);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule